// File: doc/BRIEF.md
# Monotone Constant-Weight Mealy Controller

This block is a synchronous Mealy state machine whose states use a 1-out-of-4 code. Its next-state and output logic is a two-level plane of products. Each product tests only bits that must be 1, so the logic has no inverted literal anywhere. Beyond three primary inputs, the block takes a two-bit selector of weight one from an upstream controller. Within a state, the selector picks which group of products may fire: hold the state, or advance to the next one. Each group carries its own next-state/output codeword.

The logic is monotone and no legal output word is all zeros, so a single stuck value on any product or state bit moves the outputs in one direction only. A missed product leaves the machine in the all-zero state, which then drives all-zero outputs. A downstream checker that watches only the output bus can therefore detect the fault. A fault hook on the ports forces any single product term or state bit to a chosen value.

Top module: `ucw_fsm`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) loads state code 1000 into st_o. State A is 1000, B is 0100, C is 0010 and D is 0001.
- R2: With the fault hook off and a selector of weight one or zero, a state of weight one or zero is followed by a state of weight one or zero.
- R3: Selector value 01 (aux_in[0]) holds the current state whatever x_in is. In that cycle y_o is A:00010, B:00110, C:01000, D:01001.
- R4: Selector value 10 (aux_in[1]) advances A→B, B→C, C→D, D→A when the condition bit of the state is 1. The condition bits are A:x_in[2], B:x_in[0], C:x_in[1], D:x_in[2]. In that cycle y_o is A:10010, B:10110, C:11000, D:11001.
- R5: When no product fires (selector 00, or selector 10 with the condition bit 0), y_o is 00000 in that same cycle and the next state is 0000.
- R6: From state 0000, the state stays 0000 and y_o is 00000 for every input until reset.
- R7: Selector 11 with the condition bit met makes y_o and the next state the bitwise OR of the hold codeword and the advance codeword.
- R8: Fault hook: flt_on enables it. flt_sel=0 picks product flt_idx, numbered 0..7 as A-hold, A-advance, B-hold, B-advance, C-hold, C-advance, D-hold, D-advance. flt_sel=1 picks state bit flt_idx (bit 3 is A). The picked signal is forced to flt_val.
- R9: A stuck-at-0 fault on any product or state bit only turns 1s of y_o and of the next state into 0s, compared with the fault-free values.
- R10: A stuck-at-1 fault on any product or state bit only turns 0s of y_o and of the next state into 1s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 3 | Primary inputs |
| aux_in | input | 2 | Transition selector, weight one in normal use |
| flt_on | input | 1 | Fault hook enable |
| flt_sel | input | 1 | 0 selects a product term, 1 selects a state bit |
| flt_idx | input | 3 | Index of the forced product or state bit |
| flt_val | input | 1 | Value forced on the selected signal |
| st_o | output | 4 | State register |
| y_o | output | 5 | Mealy outputs |

## Verification
Four properties are checked on every cycle. Reset lands on state A. The state weight stays at most one while the selector is legal. The dead all-zero state never recovers and keeps the outputs silent. The exact codewords of each hold and advance, the OR behaviour under a two-hot selector, and the one-directional error under every single injected fault depend on specific inputs. Only the bench sweeps show these: one sweeps all four states against all 32 extended input words, and the other sweeps each of the 24 fault settings over the legal inputs.

// File: rtl/ucw_fsm.sv
module ucw_fsm #(
  parameter int NX = 3,
  parameter int NA = 2,
  parameter int NS = 4,
  parameter int NY = 5,
  parameter int NP = 8,
  parameter logic [NP-1:0][NS+NX+NA-1:0] PMASK = {
    9'b0001_100_10, 9'b0001_000_01,
    9'b0010_010_10, 9'b0010_000_01,
    9'b0100_001_10, 9'b0100_000_01,
    9'b1000_100_10, 9'b1000_000_01},
  parameter logic [NP-1:0][NS+NY-1:0] PCODE = {
    9'b1000_11001, 9'b0001_01001,
    9'b0001_11000, 9'b0010_01000,
    9'b0010_10110, 9'b0100_00110,
    9'b0100_10010, 9'b1000_00010}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NX-1:0] x_in,
  input  logic [NA-1:0] aux_in,
  input  logic          flt_on,
  input  logic          flt_sel,
  input  logic [$clog2(NP > NS ? NP : NS)-1:0] flt_idx,
  input  logic          flt_val,
  output logic [NS-1:0] st_o,
  output logic [NY-1:0] y_o
);
  localparam int NV = NS + NX + NA;
  localparam int NC = NS + NY;
  localparam int IW = $clog2(NP > NS ? NP : NS);
  localparam logic [NS-1:0] INIT = {1'b1, {(NS-1){1'b0}}};

  logic [NS-1:0] st_q, st_v;
  logic [NV-1:0] vec;
  logic [NP-1:0] prod;
  logic [NC-1:0] full;

  for (genvar j = 0; j < NS; j++) begin : g_st
    assign st_v[j] = (flt_on && flt_sel && flt_idx == IW'(j)) ? flt_val : st_q[j];
  end

  assign vec = {st_v, x_in, aux_in};

  for (genvar p = 0; p < NP; p++) begin : g_and
    logic hit;
    assign hit = &(vec | ~PMASK[p]);
    assign prod[p] = (flt_on && !flt_sel && flt_idx == IW'(p)) ? flt_val : hit;
  end

  for (genvar b = 0; b < NC; b++) begin : g_or
    logic [NP-1:0] col;
    for (genvar p = 0; p < NP; p++) begin : g_col
      assign col[p] = PCODE[p][b];
    end
    assign full[b] = |(prod & col);
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= INIT;
    else     st_q <= full[NC-1 -: NS];
  end

  assign st_o = st_q;
  assign y_o  = full[NY-1:0];

  p_reset_init_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> st_q == INIT);

  p_weight_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (!flt_on && $onehot0(aux_in) && $onehot0(st_q)) |=> $onehot0(st_q));

  p_dead_stays_r6: assert property (@(posedge clk) disable iff (rst)
    (!flt_on && st_q == '0) |=> st_q == '0);

  p_dead_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!flt_on && st_q == '0) |-> y_o == '0);
endmodule

// File: tb/sim_ucw_fsm.sv
module sim_ucw_fsm;
  logic clk = 0, rst = 1;
  logic [2:0] x_in = '0;
  logic [1:0] aux_in = '0;
  logic flt_on = 0, flt_sel = 0, flt_val = 0;
  logic [2:0] flt_idx = '0;
  logic [3:0] st_o;
  logic [4:0] y_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  ucw_fsm u0 (.clk(clk), .rst(rst), .x_in(x_in), .aux_in(aux_in), .flt_on(flt_on),
    .flt_sel(flt_sel), .flt_idx(flt_idx), .flt_val(flt_val), .st_o(st_o), .y_o(y_o));

  always #5 clk = ~clk;

  function automatic logic [8:0] model(input logic [3:0] s, input logic [2:0] x, input logic [1:0] a);
    logic [8:0] r = '0;
    logic [4:0] hold_y[4]  = '{5'b00010, 5'b00110, 5'b01000, 5'b01001};
    logic [4:0] move_y[4]  = '{5'b10010, 5'b10110, 5'b11000, 5'b11001};
    logic cond[4];
    cond = '{x[2], x[0], x[1], x[2]};
    for (int k = 0; k < 4; k++) begin
      if (s[3-k]) begin
        if (a[0]) r |= {4'b1000 >> k, hold_y[k]};
        if (a[1] && cond[k]) r |= {4'b1000 >> ((k + 1) % 4), move_y[k]};
      end
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_dir(input string req, input logic [8:0] act, input logic [8:0] good, input logic v);
    n_chk++;
    if (v ? ((good & ~act) != 0) : ((act & ~good) != 0)) begin
      n_fail++;
      $display("FAIL %s: actual %b expected one-way change from %b", req, act, good);
    end
  endtask

  task automatic go_to(input int k);
    @(negedge clk); rst = 1; flt_on = 0; aux_in = 2'b00;
    @(negedge clk); rst = 0;
    for (int i = 0; i < k; i++) begin
      aux_in = 2'b10; x_in = 3'b111;
      @(negedge clk);
    end
  endtask

  initial begin
    logic [8:0] g;
    logic [4:0] yf;
    go_to(0);
    chk("R1 reset state", {st_o, 5'b0}, {4'b1000, 5'b0});
    for (int k = 0; k < 4; k++) begin
      go_to(k);
      chk("R1 state code", {st_o, 5'b0}, {4'b1000 >> k, 5'b0});
      for (int e = 0; e < 32; e++) begin
        go_to(k);
        x_in = e[4:2]; aux_in = e[1:0];
        #1;
        g = model(4'b1000 >> k, e[4:2], e[1:0]);
        chk(e[1:0] == 2'b11 ? "R7 out" : e[1:0] == 2'b01 ? "R3 out" : e[1:0] == 2'b10 ? "R4 R5 out" : "R5 out",
            {4'b0, y_o}, {4'b0, g[4:0]});
        @(posedge clk); #1;
        chk(e[1:0] == 2'b11 ? "R7 next" : e[1:0] == 2'b01 ? "R3 next" : "R4 R5 next",
            {st_o, 5'b0}, {g[8:5], 5'b0});
        if (st_o == 4'b0000) begin
          @(negedge clk); x_in = 3'b111; aux_in = 2'b11; #1;
          chk("R6 dead out", {4'b0, y_o}, 9'b0);
          @(posedge clk); #1;
          chk("R6 dead state", {st_o, 5'b0}, 9'b0);
        end
      end
    end
    for (int sel = 0; sel < 2; sel++)
      for (int idx = 0; idx < (sel ? 4 : 8); idx++)
        for (int v = 0; v < 2; v++)
          for (int k = 0; k < 4; k++)
            for (int e = 0; e < 16; e++) begin
              go_to(k);
              x_in = e[3:1]; aux_in = e[0] ? 2'b10 : 2'b01;
              flt_on = 1; flt_sel = sel[0]; flt_idx = idx[2:0]; flt_val = v[0];
              #1;
              g = model(4'b1000 >> k, x_in, aux_in);
              yf = y_o;
              @(posedge clk); #1;
              chk_dir(v ? "R10 R8 stuck1" : "R9 R8 stuck0", {st_o, yf}, g, v[0]);
              flt_on = 0;
            end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); n_chk++; n_fail++; $display("FAIL watchdog: actual hung expected done"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule